// File: doc/BRIEF.md
# Packet Preamble and Header Serializer

This block produces the serial bit stream at the head of every transmitted packet. When transmit enable is high, a bit-rate strobe starts a packet. The block then sends a run of sync ones of programmable length, a 16-bit start-of-frame delimiter, and a 48-bit header. The header carries a signal byte, a service byte, a 16-bit length (the payload air time in microseconds) and a CRC-16 over those 32 header bits. Each strobe moves the stream forward by exactly one bit.

The signal byte is taken from one of four programmed values, chosen by a 2-bit modulation code. All header inputs are captured when the packet starts. When the header is complete, a one-clock done pulse and the phase code tell the payload source to start supplying bits. Those bits are forwarded unchanged. When transmit enable is seen low on a payload strobe, the block sends a fixed number of zero padding bits so the transmitter can shut down cleanly. It then returns to idle.

Top module: `tx_hdr_framer`

## Requirements
- R1: After reset, tx_bit is 0, phase is 0 (idle) and hdr_done is 0.
- R2: In idle, a strobe with tx_en high starts a packet. The first pre_len bits are ones, with phase 1.
- R3: A pre_len of 0 skips the sync run: the first strobe of the packet already sends delimiter bit 0.
- R4: The 16-bit delimiter 0xF3A0 follows the sync run, least significant bit first, with phase 2.
- R5: The header is sent with phase 3 in this order: signal byte, service byte, then length, each least significant bit first. The signal byte is sig_val0..sig_val3 for mod_sel 0..3. All of these values are captured on the packet's first strobe, so later changes have no effect on the packet.
- R6: The last 16 header bits carry the ones' complement of a CRC, most significant bit first. The CRC is preset to 0xFFFF and runs over the 32 header bits in send order with polynomial 0x1021 (x^16+x^12+x^5+1).
- R7: hdr_done is high for exactly one clock, starting at the edge that puts the last CRC bit on tx_bit.
- R8: After the header, each strobe with tx_en high copies pay_bit to tx_bit, with phase 4.
- R9: A strobe with tx_en low during the sync, delimiter or header phases changes nothing. The packet resumes at the same bit on the next strobe with tx_en high.
- R10: A strobe with tx_en low during the payload starts TAIL_BITS zero bits with phase 5. tx_en has no effect during these bits. After them, the next strobe gives phase 0 with tx_bit 0.
- R11: tx_bit and phase change only on clock edges where bit_stb is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| bit_stb | input | 1 | One-clock strobe per bit period |
| pre_len | input | PRE_W | Sync run length in bits |
| sig_val0 | input | 8 | Signal byte for modulation code 0 |
| sig_val1 | input | 8 | Signal byte for modulation code 1 |
| sig_val2 | input | 8 | Signal byte for modulation code 2 |
| sig_val3 | input | 8 | Signal byte for modulation code 3 |
| mod_sel | input | 2 | Modulation code choosing the signal byte |
| svc_val | input | 8 | Service byte |
| len_val | input | 16 | Length field (payload air time, microseconds) |
| pay_bit | input | 1 | Payload bit from the payload source |
| tx_bit | output | 1 | Serial output bit |
| phase | output | 3 | Phase of tx_bit: 0 idle, 1 sync, 2 delimiter, 3 header, 4 payload, 5 tail |
| hdr_done | output | 1 | Pulse with the last header bit |

## Verification
Packets are sent with the standard 128-bit sync run, an empty run, a single-bit run and random short runs. Each packet uses all four modulation codes and random header values, so a wrong signal-byte choice, field order or bit order shows up as a CRC or field mismatch. The header inputs are changed after each packet's first strobe; this separates capture at packet start from live sampling. A tx_en drop inside the delimiter tests the hold behaviour. A tx_en pulse inside the tail tests that tx_en is ignored there. Payload lengths include zero, which exercises the move from header straight into padding.

// File: rtl/framer_pkg.sv
package framer_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_SFD  = 3'd2,
    PH_HDR  = 3'd3,
    PH_PAY  = 3'd4,
    PH_TAIL = 3'd5
  } phase_e;

  localparam logic [15:0] SFD_WORD      = 16'hF3A0;
  localparam logic [15:0] CRC_POLY      = 16'h1021;
  localparam int          HDR_DATA_BITS = 32;
  localparam int          HDR_BITS      = 48;
  localparam int          SFD_BITS      = 16;
endpackage

// File: rtl/framer_crc16.sv
module framer_crc16
  import framer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic feed,
  input  logic shift,
  input  logic din,
  output logic msb
);
  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc_q <= 16'hFFFF;
    end else if (feed) begin
      crc_q <= {crc_q[14:0], 1'b0} ^ ({16{din ^ crc_q[15]}} & CRC_POLY);
    end else if (shift) begin
      crc_q <= {crc_q[14:0], 1'b0};
    end
  end

  assign msb = crc_q[15];
endmodule

// File: rtl/framer_seq.sv
module framer_seq
  import framer_pkg::*;
#(
  parameter int PRE_W     = 8,
  parameter int TAIL_BITS = 8,
  parameter int CW        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             bit_stb,
  input  logic [PRE_W-1:0] pre_len,
  output logic             emit,
  output logic             start,
  output phase_e           cur_ph,
  output logic [CW-1:0]    cur_cnt
);
  phase_e        ph_q, nxt_ph;
  logic [CW-1:0] cnt_q, nxt_cnt;

  // position whose bit goes out on this strobe
  always_comb begin
    emit    = 1'b0;
    start   = 1'b0;
    cur_ph  = ph_q;
    cur_cnt = cnt_q;
    if (bit_stb) begin
      case (ph_q)
        PH_IDLE: begin
          emit = 1'b1;
          if (tx_en) begin
            start   = 1'b1;
            cur_ph  = (pre_len == '0) ? PH_SFD : PH_PRE;
            cur_cnt = '0;
          end
        end
        PH_PRE, PH_SFD, PH_HDR: emit = tx_en;
        PH_PAY: begin
          emit = 1'b1;
          if (!tx_en) begin
            cur_ph  = PH_TAIL;
            cur_cnt = '0;
          end
        end
        PH_TAIL: emit = 1'b1;
        default: emit = 1'b0;
      endcase
    end
  end

  // position after the emitted one
  always_comb begin
    nxt_ph  = cur_ph;
    nxt_cnt = cur_cnt + CW'(1);
    case (cur_ph)
      PH_IDLE: nxt_cnt = '0;
      PH_PRE: if (nxt_cnt == CW'(pre_len)) begin
        nxt_ph  = PH_SFD;
        nxt_cnt = '0;
      end
      PH_SFD: if (cur_cnt == CW'(SFD_BITS - 1)) begin
        nxt_ph  = PH_HDR;
        nxt_cnt = '0;
      end
      PH_HDR: if (cur_cnt == CW'(HDR_BITS - 1)) begin
        nxt_ph  = PH_PAY;
        nxt_cnt = '0;
      end
      PH_PAY: nxt_cnt = '0;
      PH_TAIL: if (cur_cnt == CW'(TAIL_BITS - 1)) begin
        nxt_ph  = PH_IDLE;
        nxt_cnt = '0;
      end
      default: begin
        nxt_ph  = PH_IDLE;
        nxt_cnt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (emit) begin
      ph_q  <= nxt_ph;
      cnt_q <= nxt_cnt;
    end
  end
endmodule

// File: rtl/tx_hdr_framer.sv
module tx_hdr_framer
  import framer_pkg::*;
#(
  parameter int PRE_W     = 8,
  parameter int TAIL_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             bit_stb,
  input  logic [PRE_W-1:0] pre_len,
  input  logic [7:0]       sig_val0,
  input  logic [7:0]       sig_val1,
  input  logic [7:0]       sig_val2,
  input  logic [7:0]       sig_val3,
  input  logic [1:0]       mod_sel,
  input  logic [7:0]       svc_val,
  input  logic [15:0]      len_val,
  input  logic             pay_bit,
  output logic             tx_bit,
  output logic [2:0]       phase,
  output logic             hdr_done
);
  localparam int TW  = $clog2(TAIL_BITS + 1);
  localparam int CW0 = (PRE_W > 6) ? PRE_W : 6;
  localparam int CW  = (CW0 > TW) ? CW0 : TW;

  logic          emit, start;
  phase_e        cur_ph;
  logic [CW-1:0] cur_cnt;
  logic [7:0]    sig_arr [4];
  logic [HDR_DATA_BITS-1:0] hdr_q;
  logic          crc_msb, in_hdr, hdr_data, cur_bit;

  assign sig_arr[0] = sig_val0;
  assign sig_arr[1] = sig_val1;
  assign sig_arr[2] = sig_val2;
  assign sig_arr[3] = sig_val3;

  framer_seq #(.PRE_W(PRE_W), .TAIL_BITS(TAIL_BITS), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .tx_en(tx_en), .bit_stb(bit_stb), .pre_len(pre_len),
    .emit(emit), .start(start), .cur_ph(cur_ph), .cur_cnt(cur_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) hdr_q <= '0;
    else if (start) hdr_q <= {len_val, svc_val, sig_arr[mod_sel]};
  end

  assign in_hdr   = emit && (cur_ph == PH_HDR);
  assign hdr_data = cur_cnt < CW'(HDR_DATA_BITS);

  framer_crc16 u_crc (
    .clk(clk), .rst(rst), .init(start),
    .feed(in_hdr && hdr_data), .shift(in_hdr && !hdr_data),
    .din(hdr_q[cur_cnt[4:0]]), .msb(crc_msb)
  );

  always_comb begin
    case (cur_ph)
      PH_PRE:  cur_bit = 1'b1;
      PH_SFD:  cur_bit = SFD_WORD[cur_cnt[3:0]];
      PH_HDR:  cur_bit = hdr_data ? hdr_q[cur_cnt[4:0]] : ~crc_msb;
      PH_PAY:  cur_bit = pay_bit;
      default: cur_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit   <= 1'b0;
      phase    <= PH_IDLE;
      hdr_done <= 1'b0;
    end else begin
      hdr_done <= in_hdr && (cur_cnt == CW'(HDR_BITS - 1));
      if (emit) begin
        tx_bit <= cur_bit;
        phase  <= cur_ph;
      end
    end
  end
endmodule

// File: rtl/framer_chk.sv
module framer_chk
  import framer_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tx_en,
  input logic       bit_stb,
  input logic       pay_bit,
  input logic       tx_bit,
  input logic [2:0] phase,
  input logic       hdr_done
);
  AST_STABLE_NO_STB: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> ($stable(tx_bit) && $stable(phase))); // R11
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    hdr_done |=> !hdr_done); // R7
  AST_DONE_IN_HDR: assert property (@(posedge clk) disable iff (rst)
    hdr_done |-> (phase == PH_HDR)); // R7
  AST_SYNC_ONES: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PRE) |-> tx_bit); // R2
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TAIL) |-> !tx_bit); // R10
  AST_PAY_COPY: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && tx_en && phase == PH_PAY) |=> (tx_bit == $past(pay_bit))); // R8
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && !tx_en && (phase == PH_PRE || phase == PH_SFD))
      |=> ($stable(phase) && $stable(tx_bit))); // R9
endmodule

bind tx_hdr_framer framer_chk u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .bit_stb(bit_stb), .pay_bit(pay_bit),
  .tx_bit(tx_bit), .phase(phase), .hdr_done(hdr_done)
);

// File: tb/tx_hdr_framer_bench.sv
module tx_hdr_framer_bench;
  localparam int CLK_PER = 10;
  localparam int PRE_W   = 8;
  localparam int TAIL    = 8;

  logic clk = 1'b0, rst = 1'b1, tx_en = 1'b0, bit_stb = 1'b0, pay_bit = 1'b0;
  logic [PRE_W-1:0] pre_len = '0;
  logic [7:0] sig_val0 = '0, sig_val1 = '0, sig_val2 = '0, sig_val3 = '0, svc_val = '0;
  logic [1:0] mod_sel = '0;
  logic [15:0] len_val = '0;
  logic tx_bit, hdr_done;
  logic [2:0] phase;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  tx_hdr_framer #(.PRE_W(PRE_W), .TAIL_BITS(TAIL)) u_tx_hdr_framer (
    .clk(clk), .rst(rst), .tx_en(tx_en), .bit_stb(bit_stb), .pre_len(pre_len),
    .sig_val0(sig_val0), .sig_val1(sig_val1), .sig_val2(sig_val2), .sig_val3(sig_val3),
    .mod_sel(mod_sel), .svc_val(svc_val), .len_val(len_val), .pay_bit(pay_bit),
    .tx_bit(tx_bit), .phase(phase), .hdr_done(hdr_done)
  );

  function automatic logic [15:0] crc_tx(input logic [31:0] w);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      logic fb = w[i] ^ c[15];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return ~c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stb_chk(input string req, input logic eb, input int eph, input logic ed);
    repeat ($urandom % 3) @(negedge clk);
    @(negedge clk) bit_stb = 1'b1;
    @(negedge clk) bit_stb = 1'b0;
    chk({req, " bit"}, tx_bit, eb);
    chk({req, " phase"}, phase, eph);
    chk({req, " hdr_done"}, hdr_done, ed);
  endtask

  task automatic scramble_regs();
    sig_val0 = 8'($urandom); sig_val1 = 8'($urandom);
    sig_val2 = 8'($urandom); sig_val3 = 8'($urandom);
    svc_val = 8'($urandom); len_val = 16'($urandom); mod_sel = 2'($urandom);
  endtask

  task automatic run_packet(input int plen, input int ms, input int npay);
    logic [7:0] sg;
    logic [31:0] w;
    logic [15:0] c;
    scramble_regs();
    mod_sel = 2'(ms);
    pre_len = PRE_W'(plen);
    case (ms)
      0: sg = sig_val0;
      1: sg = sig_val1;
      2: sg = sig_val2;
      default: sg = sig_val3;
    endcase
    w = {len_val, svc_val, sg};
    c = crc_tx(w);
    tx_en = 1'b1;
    for (int i = 0; i < plen; i++) begin
      stb_chk("R2", 1'b1, 1, 1'b0);
      if (i == 0) scramble_regs(); // R5 capture
    end
    for (int i = 0; i < 16; i++) begin
      if (i == 5) begin
        tx_en = 1'b0;
        stb_chk("R9", 16'hF3A0 >> 4, 2, 1'b0);
        tx_en = 1'b1;
      end
      stb_chk((plen == 0 && i == 0) ? "R3" : "R4", 1'((16'hF3A0 >> i)), 2, 1'b0);
      if (plen == 0 && i == 0) scramble_regs();
    end
    for (int i = 0; i < 48; i++) begin
      if (i < 32) stb_chk("R5", w[i], 3, 1'b0);
      else stb_chk((i == 47) ? "R7" : "R6", c[47 - i], 3, i == 47);
    end
    for (int j = 0; j < npay; j++) begin
      pay_bit = 1'($urandom);
      stb_chk("R8", pay_bit, 4, 1'b0);
    end
    tx_en = 1'b0;
    for (int t = 0; t < TAIL; t++) begin
      if (t == 2) tx_en = 1'b1;
      if (t == 4) tx_en = 1'b0;
      stb_chk("R10", 1'b0, 5, 1'b0);
    end
    stb_chk("R10 idle", 1'b0, 0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 bit", tx_bit, 0);
    chk("R1 phase", phase, 0);
    chk("R1 hdr_done", hdr_done, 0);
    stb_chk("R11 idle", 1'b0, 0, 1'b0);
    run_packet(128, 0, 5);
    run_packet(0, 3, 0);
    run_packet(1, 1, 3);
    run_packet(2, 2, 1);
    for (int k = 0; k < 12; k++) run_packet($urandom % 24, $urandom % 4, $urandom % 20);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule